// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between a CPU with a 16-bit address bus and a physical store of four 16 KB ROM pages and eight 16 KB RAM pages. The CPU space is cut into four 16 KB slots by address bits 15:14. For every access the block reports three things: whether the slot holds ROM or RAM, which physical page it uses, and whether a write may reach memory. The physical address is the page number with CPU address bits 13:0 appended.

Two write-only configuration bytes are loaded by I/O writes and select the layout. The main byte picks the RAM page in the top slot and one bit of the ROM page. The extended byte supplies the other ROM page bit. It can also switch the whole space to RAM in one of four fixed layouts. A sticky lock, set through the main byte, forces a fixed layout until reset. The address-to-page decode is combinational, so a memory cycle that follows a register update already uses the new layout.

Top module: `mem_pager`

## Requirements
- R1: After synchronous reset, both configuration bytes and the lock are zero. The layout is then ROM 0 in slot 0, RAM 5 in slot 1, RAM 2 in slot 2 and RAM 0 in slot 3.
- R2: `phys_addr` equals `{phys_page, mem_addr[13:0]}`. The slot is `mem_addr[15:14]`.
- R3: In normal mode (extended bit 0 clear, unlocked), slot 0 is ROM with a 2-bit page index. Extended bit 2 gives the high bit of the index and main bit 4 gives the low bit.
- R4: In normal mode, slot 1 is RAM 5, slot 2 is RAM 2, and slot 3 is the RAM page in main bits 2:0.
- R5: When extended bit 0 is set and the block is unlocked, every slot is RAM and the main byte has no effect. Extended bits 2:1 select the layout for slots 0..3: 00 gives 0,1,2,3; 01 gives 4,5,6,7; 10 gives 4,5,6,3; 11 gives 4,7,6,3.
- R6: While locked, the layout is ROM 0, RAM 5, RAM 2, RAM 0, whatever the two bytes hold.
- R7: `wr_en` equals `mem_wr` when the slot maps RAM and is 0 when it maps ROM.
- R8: An I/O write with `io_addr[15:12]`=0001 and `io_addr[1]`=0 loads the extended byte only. Any other I/O write with `io_addr[15]`=0 and `io_addr[1]`=0 loads the main byte. I/O writes with `io_addr[1]`=1 change nothing.
- R9: A main-byte write with data bit 5 set sets the lock. The lock stays set until reset, and both bytes ignore writes while it is set.
- R10: A register write takes effect at the clock edge that samples `io_wr`. Up to that edge the old layout holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data |
| mem_addr | input | 16 | CPU memory address |
| mem_wr | input | 1 | CPU memory write request |
| is_rom | output | 1 | High when the addressed slot maps ROM |
| phys_page | output | 3 | Physical page number (ROM uses bits 1:0) |
| phys_addr | output | 17 | Page number followed by the 14-bit offset |
| wr_en | output | 1 | Gated write enable to memory |

## Verification
The four slots are swept with random offsets, once with a write request and once without. ROM-index patterns 0 to 3 are reached from both register bits, which separates the high-bit source from the low-bit source. All four all-RAM codes are applied, each followed by a main-byte write, to show that the layouts differ and that the main byte has no effect. Port addresses matching both decodes, and addresses with bit 1 set, show that decode priority and rejection work. A check taken just before the update edge separates registered timing from combinational timing. After the lock is set, writes are applied to confirm that it is sticky.

// File: rtl/pager_pkg.sv
package pager_pkg;

  typedef struct packed {
    logic [2:0] ram_hi;    // main byte bits 2:0
    logic       rom_lo;    // main byte bit 4
    logic       allram;    // extended bit 0
    logic [1:0] layout;    // extended bits 2:1 (bit 2 doubles as ROM high bit)
    logic       lock;
  } pager_cfg_t;

  typedef struct packed {
    logic       rom;
    logic [2:0] page;
  } slot_ent_t;

  function automatic slot_ent_t slot_lookup(input pager_cfg_t c, input int idx);
    slot_ent_t e;
    e.rom  = 1'b0;
    e.page = 3'd0;
    if (c.lock) begin
      case (idx)
        0: begin e.rom = 1'b1; e.page = 3'd0; end
        1: e.page = 3'd5;
        2: e.page = 3'd2;
        default: e.page = 3'd0;
      endcase
    end else if (c.allram) begin
      case (idx)
        0: e.page = (c.layout == 2'b00) ? 3'd0 : 3'd4;
        1: case (c.layout)
             2'b00:   e.page = 3'd1;
             2'b11:   e.page = 3'd7;
             default: e.page = 3'd5;
           endcase
        2: e.page = (c.layout == 2'b00) ? 3'd2 : 3'd6;
        default: e.page = (c.layout == 2'b01) ? 3'd7 : 3'd3;
      endcase
    end else begin
      case (idx)
        0: begin e.rom = 1'b1; e.page = {1'b0, c.layout[1], c.rom_lo}; end
        1: e.page = 3'd5;
        2: e.page = 3'd2;
        default: e.page = c.ram_hi;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs
  import pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_data,
  output pager_cfg_t        cfg
);
  localparam int TOP = ADDR_W - 1;

  logic hit_ext, hit_main;
  assign hit_ext  = io_wr && !cfg.lock && (io_addr[TOP -: 4] == 4'b0001) && !io_addr[1];
  assign hit_main = io_wr && !cfg.lock && !io_addr[TOP] && !io_addr[1] && !hit_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (hit_main) begin
        cfg.ram_hi <= io_data[2:0];
        cfg.rom_lo <= io_data[4];
        if (io_data[5]) cfg.lock <= 1'b1;
      end
      if (hit_ext) begin
        cfg.allram <= io_data[0];
        cfg.layout <= io_data[2:1];
      end
    end
  end

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cfg.lock |=> cfg.lock);
  p_locked_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    cfg.lock |=> ($stable(cfg.ram_hi) && $stable(cfg.rom_lo) &&
                  $stable(cfg.allram) && $stable(cfg.layout)));
  p_no_load_odd_port_r8: assert property (@(posedge clk) disable iff (rst)
    (io_addr[1] || !io_wr) |=> ($stable(cfg.ram_hi) && $stable(cfg.layout) && $stable(cfg.allram)));
endmodule

// File: rtl/pg_slot_map.sv
module pg_slot_map
  import pager_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  pager_cfg_t cfg,
  input  logic [SLOT_W-1:0] slot,
  output slot_ent_t  ent
);
  localparam int NSLOT = 1 << SLOT_W;

  slot_ent_t table_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign table_q[s] = slot_lookup(cfg, s);
  end

  assign ent = table_q[slot];
endmodule

// File: rtl/mem_pager.sv
module mem_pager
  import pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_wr,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic [DATA_W-1:0]        io_data,
  input  logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_wr,
  output logic                     is_rom,
  output logic [PAGE_W-1:0]        phys_page,
  output logic [PAGE_W+ADDR_W-3:0] phys_addr,
  output logic                     wr_en
);
  localparam int SLOT_W = 2;
  localparam int OFF_W  = ADDR_W - SLOT_W;

  pager_cfg_t cfg;
  slot_ent_t  ent;
  logic [SLOT_W-1:0] slot;

  assign slot = mem_addr[ADDR_W-1 -: SLOT_W];

  pg_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .cfg(cfg)
  );

  pg_slot_map #(.SLOT_W(SLOT_W)) u_map (
    .cfg(cfg), .slot(slot), .ent(ent)
  );

  assign is_rom    = ent.rom;
  assign phys_page = PAGE_W'(ent.page);
  assign phys_addr = {phys_page, mem_addr[OFF_W-1:0]};
  assign wr_en     = mem_wr & ~ent.rom;

  p_rom_only_slot0_r3: assert property (@(posedge clk) disable iff (rst)
    is_rom |-> (slot == '0));
  p_allram_no_rom_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg.allram && !cfg.lock) |-> !is_rom);
  p_lock_slot1_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg.lock && slot == 2'd1) |-> (phys_page == 3'd5 && !is_rom));
  p_lock_slot0_rom0_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg.lock && slot == 2'd0) |-> (is_rom && phys_page == 3'd0));
endmodule

// File: tb/mem_pager_bench.sv
`timescale 1ns/1ps
module mem_pager_bench;
  logic        clk = 0, rst = 1, io_wr = 0, mem_wr = 0;
  logic [15:0] io_addr = 0, mem_addr = 0;
  logic [7:0]  io_data = 0;
  logic        is_rom, wr_en;
  logic [2:0]  phys_page;
  logic [16:0] phys_addr;

  int total = 0, bad = 0;
  int m_main = 0, m_ext = 0;
  bit m_lock = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_pager u_mem_pager (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .is_rom(is_rom),
    .phys_page(phys_page), .phys_addr(phys_addr), .wr_en(wr_en)
  );

  function automatic void model_map(input int s, output int pg, output bit rom);
    int lay;
    lay = (m_ext >> 1) & 3;
    rom = 0;
    if (m_lock) begin
      int lk[4] = '{0, 5, 2, 0};
      pg = lk[s]; rom = (s == 0);
    end else if (m_ext & 1) begin
      int t0[4] = '{0, 1, 2, 3};
      int t1[4] = '{4, 5, 6, 7};
      int t2[4] = '{4, 5, 6, 3};
      int t3[4] = '{4, 7, 6, 3};
      case (lay)
        0: pg = t0[s];
        1: pg = t1[s];
        2: pg = t2[s];
        default: pg = t3[s];
      endcase
    end else begin
      case (s)
        0: begin rom = 1; pg = (((m_ext >> 2) & 1) << 1) | ((m_main >> 4) & 1); end
        1: pg = 5;
        2: pg = 2;
        default: pg = m_main & 7;
      endcase
    end
  endfunction

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        int pg; bit rom; int off;
        model_map(s, pg, rom);
        off = $urandom_range(0, 16383);
        mem_addr = 16'((s << 14) | off);
        mem_wr = w[0];
        #0.25;
        total++;
        if (is_rom !== rom || phys_page !== 3'(pg)) begin
          bad++;
          $display("FAIL %s slot%0d: rom=%0d page=%0d expected rom=%0d page=%0d",
                   tag, s, is_rom, phys_page, rom, pg);
        end
        total++;
        if (phys_addr !== 17'((pg << 14) | off)) begin
          bad++;
          $display("FAIL R2 slot%0d: addr=%h expected %h", s, phys_addr, 17'((pg << 14) | off));
        end
        total++;
        if (wr_en !== (w[0] && !rom)) begin
          bad++;
          $display("FAIL R7 slot%0d: wr_en=%0d expected %0d", s, wr_en, (w[0] && !rom));
        end
      end
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    bit hx, hm;
    @(negedge clk);
    io_addr = a; io_data = d; io_wr = 1;
    check_all("R10");
    @(posedge clk);
    hx = !m_lock && (a[15:12] == 4'b0001) && !a[1];
    hm = !m_lock && !a[15] && !a[1] && !hx;
    if (hx) m_ext = d & 7;
    if (hm) begin
      m_main = d;
      if (d[5]) m_lock = 1;
    end
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; m_main = 0; m_ext = 0; m_lock = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); check_all("R1");
    // R3/R4: ROM index from both bits, slot 3 RAM page
    io_write(16'h7FFD, 8'h17); @(negedge clk); check_all("R3");
    io_write(16'h1FFD, 8'h04); @(negedge clk); check_all("R3");
    io_write(16'h7FFD, 8'h02); @(negedge clk); check_all("R4");
    io_write(16'h1FFD, 8'h00); @(negedge clk); check_all("R3");
    io_write(16'h3FFC, 8'h15); @(negedge clk); check_all("R4");
    // R8: rejected port, then a port that hits both decodes
    io_write(16'h7FFF, 8'h06); @(negedge clk); check_all("R8");
    io_write(16'h1FFD, 8'h04); @(negedge clk); check_all("R8");
    io_write(16'hFFFD, 8'h00); @(negedge clk); check_all("R8");
    // R5: all four all-RAM layouts, main byte has no effect
    for (int k = 0; k < 4; k++) begin
      io_write(16'h1FFD, 8'((k << 1) | 1)); @(negedge clk); check_all("R5");
      io_write(16'h7FFD, 8'(k + 1));        @(negedge clk); check_all("R5");
    end
    io_write(16'h1FFD, 8'h00); @(negedge clk); check_all("R4");
    // R6/R9: lock, then attempts to change mapping
    io_write(16'h7FFD, 8'h37); @(negedge clk); check_all("R6");
    io_write(16'h1FFD, 8'h07); @(negedge clk); check_all("R9");
    io_write(16'h7FFD, 8'h05); @(negedge clk); check_all("R9");
    repeat (3) @(negedge clk); check_all("R9");
    do_reset(); @(negedge clk); check_all("R1");
    io_write(16'h7FFD, 8'h03); @(negedge clk); check_all("R9");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule